// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point words (1 sign bit, 8 exponent bits biased by 127, 23 fraction bits) and returns their product one clock later, with four status flags. The sign of the result is the exclusive-or of the operand signs. The two biased exponents are added and the bias is taken out once. The two 24-bit significands are multiplied and the product is normalised with at most one right shift. The fraction is truncated toward zero.

A zero operand is recognised from its exponent field. An exponent field of all zeros means zero; a nonzero fraction with that exponent is also treated as zero. Such an operand gives a signed zero result. An exponent sum too small to carry the bias is flushed to a signed zero. An adjusted exponent that reaches the all-ones code saturates to a signed infinity. Any infinity or NaN operand produces one fixed quiet-NaN word. At most one flag is raised for each result.

Top module: `fpm_mul32`

## Requirements
- R1: Product and flags are registered: they change only at the rising clock edge after the operands are applied. A synchronous active-high reset clears the product and all four flags to zero.
- R2: Bit 31 of the product is the XOR of operand bits 31 for every result except the exception word. This includes signed zeros and signed infinities.
- R3: For finite nonzero operands whose 9-bit exponent sum has bit 8 or bit 7 set, the product exponent (bits 30:23) is the sum minus 127, plus the normalisation increment.
- R4: The 48-bit significand product is normalised on bit 47. If bit 47 is set, the fraction comes from bits 46:24 and the exponent gains 1. Otherwise the fraction comes from bits 45:23.
- R5: Fraction bits below the kept 23 are discarded (truncation toward zero), so 0x3FFFFFFF times itself gives 0x407FFFFE.
- R6: If both operands are finite and nonzero and bits 8 and 7 of the exponent sum are both zero, the product is a signed zero and the underflow flag is 1. This holds even when a normalisation shift would follow.
- R7: If the adjusted exponent is 255 or more, the product is a signed infinity (exponent 0xFF, fraction 0) and the overflow flag is 1.
- R8: An operand with exponent field 0 counts as zero. If no exception is present, the product is a signed zero and the zero flag is 1. For example, 0xC1526666 times 0x00000000 gives 0x80000000.
- R9: If either operand has exponent field 0xFF, the product is 0x7FC00000 and the exception flag is 1. The other three flags are 0, even when the other operand is zero.
- R10: At most one of the four flags is 1 in any cycle. The priority is exception, then zero, then underflow, then overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| product | output | 32 | Registered product word |
| flag_exc | output | 1 | Infinity or NaN operand seen |
| flag_ovf | output | 1 | Result saturated to infinity |
| flag_unf | output | 1 | Exponent sum flushed to zero |
| flag_zero | output | 1 | Zero operand seen |

## Verification
The normalisation increment and the overflow test can fall in the same cycle. The increment alone can be what pushes the exponent from 254 to 255. This is provoked with 0x7F400000 times 1.5, which must saturate to infinity with the overflow flag set. The same large operand times 1.0 must pass through unchanged. A second overlap is an infinity times a zero: both the exception and the zero conditions hold, and only the exception word and flag may appear.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef struct packed {
    logic exc;
    logic ovf;
    logic unf;
    logic zero;
  } fpm_flags_t;

  localparam int FPM_FLAG_W = $bits(fpm_flags_t);

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic [W-1:0]     op,
  output logic             sgn,
  output logic [EXP_W-1:0] expo,
  output logic [SIG_W-1:0] sig,
  output logic             is_zero,
  output logic             is_spec
);

  logic [FRAC_W-1:0] frac;

  always_comb begin
    sgn     = op[W-1];
    expo    = op[W-2:FRAC_W];
    frac    = op[FRAC_W-1:0];
    is_zero = (expo == '0);
    is_spec = &expo;
    // subnormal encodings collapse to zero: no hidden one, no fraction
    sig     = is_zero ? '0 : {1'b1, frac};
  end

endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
  parameter int FRAC_W  = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [SIG_W-1:0]  sig_a,
  input  logic [SIG_W-1:0]  sig_b,
  output logic [FRAC_W-1:0] frac,
  output logic              norm
);

  logic [PROD_W-1:0] prod;
  int unsigned       shamt;

  always_comb begin
    prod  = PROD_W'(sig_a) * PROD_W'(sig_b);
    norm  = prod[PROD_W-1];
    shamt = norm ? FRAC_W + 1 : FRAC_W;
    // keep FRAC_W bits below the leading one; lower bits are dropped
    frac  = FRAC_W'(prod >> shamt);
  end

endmodule

// File: rtl/fpm_exp_path.sv
module fpm_exp_path #(
  parameter int EXP_W  = 8,
  localparam int ESUM_W = EXP_W + 1,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX   = (1 << EXP_W) - 1
) (
  input  logic [EXP_W-1:0] exp_a,
  input  logic [EXP_W-1:0] exp_b,
  input  logic             norm,
  output logic [EXP_W-1:0] exp_res,
  output logic             flush,
  output logic             over
);

  logic [ESUM_W-1:0] esum;
  logic [ESUM_W-1:0] eadj;

  always_comb begin
    esum  = ESUM_W'(exp_a) + ESUM_W'(exp_b);
    // sum below BIAS+1 cannot absorb the bias subtraction
    flush = ~(esum[ESUM_W-1] | esum[EXP_W-1]);
    if (flush) begin
      eadj = '0;
    end else begin
      eadj = esum + ESUM_W'(norm) - ESUM_W'(BIAS);
    end
    over    = ~flush & (eadj >= ESUM_W'(EMAX));
    exp_res = EXP_W'(eadj);
  end

endmodule

// File: rtl/fpm_mul32.sv
module fpm_mul32
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int NOPS  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] product,
  output logic         flag_exc,
  output logic         flag_ovf,
  output logic         flag_unf,
  output logic         flag_zero
);

  localparam logic [W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0]     ops     [NOPS];
  logic             sgn_v   [NOPS];
  logic [EXP_W-1:0] exp_v   [NOPS];
  logic [SIG_W-1:0] sig_v   [NOPS];
  logic             zero_v  [NOPS];
  logic             spec_v  [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .op      (ops[gi]),
      .sgn     (sgn_v[gi]),
      .expo    (exp_v[gi]),
      .sig     (sig_v[gi]),
      .is_zero (zero_v[gi]),
      .is_spec (spec_v[gi])
    );
  end

  logic [FRAC_W-1:0] frac_n;
  logic              norm;
  logic [EXP_W-1:0]  exp_n;
  logic              flush;
  logic              over;

  fpm_sig_mul #(.FRAC_W(FRAC_W)) u_sig_mul (
    .sig_a (sig_v[0]),
    .sig_b (sig_v[1]),
    .frac  (frac_n),
    .norm  (norm)
  );

  fpm_exp_path #(.EXP_W(EXP_W)) u_exp_path (
    .exp_a   (exp_v[0]),
    .exp_b   (exp_v[1]),
    .norm    (norm),
    .exp_res (exp_n),
    .flush   (flush),
    .over    (over)
  );

  logic       sgn_r;
  logic       any_zero;
  logic       any_spec;
  logic [W-1:0] word_d;
  fpm_flags_t flags_d;
  fpm_flags_t flags_q;

  always_comb begin
    sgn_r    = sgn_v[0] ^ sgn_v[1];
    any_zero = zero_v[0] | zero_v[1];
    any_spec = spec_v[0] | spec_v[1];
    flags_d  = '0;
    if (any_spec) begin
      word_d       = QNAN_WORD;
      flags_d.exc  = 1'b1;
    end else if (any_zero) begin
      word_d       = {sgn_r, {(W-1){1'b0}}};
      flags_d.zero = 1'b1;
    end else if (flush) begin
      word_d       = {sgn_r, {(W-1){1'b0}}};
      flags_d.unf  = 1'b1;
    end else if (over) begin
      word_d       = {sgn_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      flags_d.ovf  = 1'b1;
    end else begin
      word_d       = {sgn_r, exp_n, frac_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      flags_q <= '0;
    end else begin
      product <= word_d;
      flags_q <= flags_d;
    end
  end

  assign flag_exc  = flags_q.exc;
  assign flag_ovf  = flags_q.ovf;
  assign flag_unf  = flags_q.unf;
  assign flag_zero = flags_q.zero;

endmodule

// File: rtl/fpm_mul32_chk.sv
module fpm_mul32_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             a_sgn,
  input logic             b_sgn,
  input logic [EXP_W-1:0] a_exp,
  input logic [EXP_W-1:0] b_exp,
  input logic [W-1:0]     product,
  input logic             flag_exc,
  input logic             flag_ovf,
  input logic             flag_unf,
  input logic             flag_zero
);

  logic in_spec;
  logic in_zero;
  assign in_spec = (&a_exp) | (&b_exp);
  assign in_zero = (a_exp == '0) | (b_exp == '0);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (product == '0 && !flag_exc && !flag_ovf && !flag_unf && !flag_zero));

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
    !in_spec |=> product[W-1] == $past(a_sgn ^ b_sgn));

  // R6
  unf_word_chk: assert property (@(posedge clk) disable iff (rst)
    flag_unf |-> product[W-2:0] == '0);

  // R7
  ovf_word_chk: assert property (@(posedge clk) disable iff (rst)
    flag_ovf |-> product[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  // R8
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (in_zero && !in_spec) |=> (flag_zero && product[W-2:0] == '0));

  // R9
  exc_in_chk: assert property (@(posedge clk) disable iff (rst)
    in_spec |=> (flag_exc && !flag_zero && product == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));

  // R10
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_exc, flag_ovf, flag_unf, flag_zero}));

endmodule

bind fpm_mul32 fpm_mul32_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_sgn     (op_a[W-1]),
  .b_sgn     (op_b[W-1]),
  .a_exp     (op_a[W-2:FRAC_W]),
  .b_exp     (op_b[W-2:FRAC_W]),
  .product   (product),
  .flag_exc  (flag_exc),
  .flag_ovf  (flag_ovf),
  .flag_unf  (flag_unf),
  .flag_zero (flag_zero)
);

// File: tb/tb_fpm_mul32.sv
module tb_fpm_mul32;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  // {req[3:0], op_a, op_b, expected product, flags {exc,ovf,unf,zero}}
  localparam logic [103:0] VEC [NV] = '{
    {4'd3,  32'h40000000, 32'h40400000, 32'h40C00000, 4'b0000}, // R3 2*3
    {4'd2,  32'hC0000000, 32'h40400000, 32'hC0C00000, 4'b0000}, // R2 -2*3
    {4'd2,  32'hBFC00000, 32'hBFC00000, 32'h40100000, 4'b0000}, // R2 neg*neg
    {4'd2,  32'h3F800000, 32'hBF800000, 32'hBF800000, 4'b0000}, // R2 1*-1
    {4'd3,  32'h3F000000, 32'h40800000, 32'h40000000, 4'b0000}, // R3 power of two
    {4'd4,  32'h3FC00000, 32'h3FC00000, 32'h40100000, 4'b0000}, // R4 shift case
    {4'd5,  32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 4'b0000}, // R5 truncation
    {4'd7,  32'h7F000000, 32'h40000000, 32'h7F800000, 4'b0100}, // R7
    {4'd7,  32'hFF000000, 32'h40000000, 32'hFF800000, 4'b0100}, // R7 negative
    {4'd7,  32'h7F400000, 32'h3FC00000, 32'h7F800000, 4'b0100}, // R7 via shift
    {4'd4,  32'h7F400000, 32'h3F800000, 32'h7F400000, 4'b0000}, // R4 no shift, 254
    {4'd6,  32'h00800000, 32'h3F000000, 32'h00000000, 4'b0010}, // R6 sum 127
    {4'd6,  32'h80800000, 32'h3F000000, 32'h80000000, 4'b0010}, // R6 negative
    {4'd3,  32'h00800000, 32'h3F800000, 32'h00800000, 4'b0000}, // R3 sum 128
    {4'd8,  32'hC1526666, 32'h00000000, 32'h80000000, 4'b0001}, // R8 -13.15*0
    {4'd8,  32'h00000000, 32'h00000000, 32'h00000000, 4'b0001}, // R8
    {4'd8,  32'h00000001, 32'h3F800000, 32'h00000000, 4'b0001}, // R8 subnormal
    {4'd8,  32'h00000000, 32'h7F000000, 32'h00000000, 4'b0001}, // R8 no overflow
    {4'd9,  32'h7F800000, 32'h3F800000, 32'h7FC00000, 4'b1000}, // R9
    {4'd10, 32'h7F800000, 32'h00000000, 32'h7FC00000, 4'b1000}, // R10 inf*0
    {4'd9,  32'hBFC00000, 32'hFFC00001, 32'h7FC00000, 4'b1000}  // R9 NaN
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] product;
  logic        flag_exc, flag_ovf, flag_unf, flag_zero;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_mul32 dut (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .product   (product),
    .flag_exc  (flag_exc),
    .flag_ovf  (flag_ovf),
    .flag_unf  (flag_unf),
    .flag_zero (flag_zero)
  );

  task automatic check(input int req, input logic [31:0] exp_w, input logic [3:0] exp_f);
    logic [3:0] got_f;
    got_f = {flag_exc, flag_ovf, flag_unf, flag_zero};
    n_chk++;
    if (product !== exp_w || got_f !== exp_f) begin
      n_bad++;
      $display("FAIL R%0d: product %h flags %b, expected %h flags %b",
               req, product, got_f, exp_w, exp_f);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_a = a;
    op_b = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, 32'h0, 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][99:68], VEC[i][67:36]);
      @(negedge clk);
      check(int'(VEC[i][103:100]), VEC[i][35:4], VEC[i][3:0]);
    end

    // R1: output holds until the next rising edge
    apply(32'h40000000, 32'h40400000);
    @(negedge clk);
    check(1, 32'h40C00000, 4'b0000);
    op_a = 32'h3F800000;
    op_b = 32'hBF800000;
    #1;
    check(1, 32'h40C00000, 4'b0000);
    @(negedge clk);
    check(1, 32'hBF800000, 4'b0000);

    // R1: synchronous reset in mid-run clears an overflow result
    apply(32'h7F000000, 32'h40000000);
    @(negedge clk);
    check(7, 32'h7F800000, 4'b0100);
    rst = 1'b1;
    #1;
    check(1, 32'h7F800000, 4'b0100);
    @(negedge clk);
    check(1, 32'h0, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check(7, 32'h7F800000, 4'b0100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule